// File: doc/BRIEF.md
# Parallel NAND Flash Host Controller

This block sits between a local request port and a byte-wide NAND flash device whose command, address and data bytes all travel over one shared 8-bit bus. A host asks for one of five operations (page read, page program, block erase, status read, device reset). The controller then produces the chip-enable, command-latch, address-latch, write and read strobes in the right order. It presents each byte on the bus at the right moment and waits on the device's ready/busy line wherever the device works internally.

The device page is 528 bytes (512 data plus 16 spare), an erase block is 16 pages, and the device has 1024 blocks. Page data streams through byte-wide valid/ready ports. Program bytes come from the host until it marks the last one or the page end is reached. Read bytes run from the requested column to the end of the page. After a program or erase the controller reads the device status byte by itself and returns it with the completion pulse. A busy wait that lasts too long ends the operation with an error flag.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset the controller is idle: req_ready=1, ce_n=1, we_n=1, re_n=1, wp_n=0, io_oe=0, done=0, err=0.
- R2: req_op encodings: 0 read (command 00h), 1 program (80h, later 10h), 2 erase (60h, later D0h), 3 status (70h), 4 reset (FFh). Every command byte is written with cle=1 and ale=0.
- R3: cle and ale are never high together. Address bytes are written with ale=1, cle=0. Data bytes are written with both low. While re_n is low, cle, ale and io_oe are all low.
- R4: Read and program write four address bytes in this order: col[7:0], col[9:8] in bits 1:0, row[7:0], row[13:8] in bits 5:0, where row = {block[9:0], page[3:0]}. Erase writes only the two row bytes, with the page field forced to 0.
- R5: A program accepts bytes on the wr port starting at the requested column. The data phase ends after the byte flagged wr_last or after the byte for column 527, whichever comes first. The confirm command follows, and no further byte is accepted.
- R6: wp_n is high for the whole of a program or erase, including both confirm commands, and low at all other times.
- R7: A read waits until rb_n reports ready before the first RE pulse. It then delivers exactly 528-col bytes, columns col..527 in order. rd_data stays stable while rd_valid is high and rd_ready is low.
- R8: Each RE pulse stays low for exactly RE_LO clocks and high for at least RE_HI clocks. The defaults (5 and 5 at 200 MHz) give a 50 ns read cycle.
- R9: When a program or erase finishes busy, the controller writes 70h, reads one status byte onto status, and then pulses done. Bit 0 of that byte is the device's fail flag.
- R10: If rb_n stays low for BUSY_TO clocks, the operation ends with done and err=1 and the controller returns to idle. err clears when the next request is accepted.
- R11: The status operation writes only 70h and returns the read byte on status. The reset operation writes only FFh and waits for ready before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_op | input | 3 | Operation code |
| req_block | input | 10 | Erase block number |
| req_page | input | 4 | Page within block |
| req_col | input | 10 | Starting column 0..527 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy timeout flag |
| status | output | 8 | Last device status byte |
| wr_valid | input | 1 | Program byte present |
| wr_ready | output | 1 | Program byte taken |
| wr_data | input | 8 | Program byte |
| wr_last | input | 1 | Last program byte from host |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| ce_n | output | 1 | Device chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| wp_n | output | 1 | Write protect, active low |
| io_out | output | 8 | Bus byte driven to device |
| io_oe | output | 1 | Bus drive enable |
| io_in | input | 8 | Bus byte from device |
| rb_n | input | 1 | Device ready (1) or busy (0) |

## Verification
The hardest case to reach is the page-end cut-off during a program. The host must offer more bytes than fit between the starting column and column 527, so the controller ends the data phase with wr_last never seen. The stimulus does this with a directed program at column 500 that offers 40 bytes, and with random starting columns that sometimes leave only a few bytes of room. A behavioural device model in the bench logs every write cycle, so the byte count and the command that follows can be compared with what the requirements predict. The busy timeout is reached by having the model hold rb_n low indefinitely during an erase.

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl #(
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = 10,
  parameter int BLK_W      = 10,
  parameter int PG_W       = 4,
  parameter int COL_CYC    = 2,
  parameter int ROW_CYC    = 2,
  parameter int WE_SU      = 1,
  parameter int WE_LO      = 3,
  parameter int WE_HI      = 2,
  parameter int RE_SU      = 1,
  parameter int RE_LO      = 5,
  parameter int RE_HI      = 5,
  parameter int T_WB       = 20,
  parameter int BUSY_TO    = 12000,
  parameter logic [7:0] OPC_READ  = 8'h00,
  parameter logic [7:0] OPC_PROG  = 8'h80,
  parameter logic [7:0] OPC_PCFM  = 8'h10,
  parameter logic [7:0] OPC_ERASE = 8'h60,
  parameter logic [7:0] OPC_ECFM  = 8'hD0,
  parameter logic [7:0] OPC_STAT  = 8'h70,
  parameter logic [7:0] OPC_RST   = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [BLK_W-1:0] req_block,
  input  logic [PG_W-1:0]  req_page,
  input  logic [COL_W-1:0] req_col,
  output logic             done,
  output logic             err,
  output logic [7:0]       status,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             wp_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);
  localparam int AC  = COL_CYC + ROW_CYC;
  localparam int RW  = BLK_W + PG_W;
  localparam int TW  = $clog2(BUSY_TO + T_WB + WE_SU + WE_LO + WE_HI + RE_SU + RE_LO + RE_HI + 2);
  localparam int AIW = $clog2(AC + 1);
  localparam logic [TW-1:0] W_ON  = TW'(WE_SU);
  localparam logic [TW-1:0] W_OFF = TW'(WE_SU + WE_LO);
  localparam logic [TW-1:0] W_END = TW'(WE_SU + WE_LO + WE_HI - 1);
  localparam logic [TW-1:0] R_ON  = TW'(RE_SU);
  localparam logic [TW-1:0] R_OFF = TW'(RE_SU + RE_LO);
  localparam logic [TW-1:0] R_END = TW'(RE_SU + RE_LO + RE_HI - 1);
  localparam logic [TW-1:0] R_CAP = TW'(RE_SU + RE_LO - 1);
  localparam logic [TW-1:0] WB    = TW'(T_WB);
  localparam logic [TW-1:0] TO    = TW'(BUSY_TO);
  localparam logic [2:0] K_RD = 3'd0, K_PG = 3'd1, K_ER = 3'd2, K_ST = 3'd3, K_RS = 3'd4;

  typedef enum logic [3:0] {S_IDLE, S_CMD, S_ADR, S_WR, S_CFM, S_BSY, S_RD, S_OUT, S_SCMD, S_SRD} st_t;

  st_t              st;
  logic [2:0]       op;
  logic [RW-1:0]    row;
  logic [COL_W-1:0] col;
  logic [TW-1:0]    tmr;
  logic [AIW-1:0]   aix;
  logic             act, lastb, done_q, err_q;
  logic [7:0]       dbuf, rdbuf, stat_q, cmd_b;
  logic [8*AC-1:0]  avec;

  wire rd_ph  = (st == S_RD) || (st == S_SRD);
  wire wr_ph  = (st == S_CMD) || (st == S_ADR) || (st == S_CFM) || (st == S_SCMD) || (st == S_WR && act);
  wire [TW-1:0] t_on  = rd_ph ? R_ON  : W_ON;
  wire [TW-1:0] t_off = rd_ph ? R_OFF : W_OFF;
  wire [TW-1:0] t_end = rd_ph ? R_END : W_END;
  wire strobe = (tmr >= t_on) && (tmr < t_off);
  wire cyc_end = (tmr == t_end);
  wire page_end = (col == COL_W'(PAGE_BYTES - 1));

  assign avec = {(8*ROW_CYC)'(row), (8*COL_CYC)'(col)};

  always_comb begin
    case (st)
      S_SCMD:  cmd_b = OPC_STAT;
      S_CFM:   cmd_b = (op == K_PG) ? OPC_PCFM : OPC_ECFM;
      default: case (op)
                 K_PG:    cmd_b = OPC_PROG;
                 K_ER:    cmd_b = OPC_ERASE;
                 K_RS:    cmd_b = OPC_RST;
                 default: cmd_b = OPC_READ;
               endcase
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign ce_n      = (st == S_IDLE);
  assign cle       = (st == S_CMD) || (st == S_CFM) || (st == S_SCMD);
  assign ale       = (st == S_ADR);
  assign we_n      = !(wr_ph && strobe);
  assign re_n      = !(rd_ph && strobe);
  assign io_oe     = wr_ph;
  assign io_out    = (st == S_ADR) ? avec[8*int'(aix) +: 8] : (st == S_WR) ? dbuf : cmd_b;
  assign wp_n      = (st != S_IDLE) && (op == K_PG || op == K_ER);
  assign wr_ready  = (st == S_WR) && !act;
  assign rd_valid  = (st == S_OUT);
  assign rd_data   = rdbuf;
  assign status    = stat_q;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= K_RD; row <= '0; col <= '0; tmr <= '0; aix <= '0;
      act <= 1'b0; lastb <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      dbuf <= '0; rdbuf <= '0; stat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE && st != S_OUT && !(st == S_WR && !act)) tmr <= tmr + 1'b1;
      if (rd_ph && tmr == R_CAP) begin
        if (st == S_RD) rdbuf <= io_in;
        else            stat_q <= io_in;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          op    <= req_op;
          row   <= {req_block, (req_op == K_ER) ? PG_W'(0) : req_page};
          col   <= req_col;
          aix   <= (req_op == K_ER) ? AIW'(COL_CYC) : '0;
          err_q <= 1'b0;
          tmr   <= '0;
          act   <= 1'b0;
          st    <= (req_op == K_ST) ? S_SCMD : S_CMD;
        end
        S_CMD: if (cyc_end) begin
          tmr <= '0;
          st  <= (op == K_RS) ? S_BSY : S_ADR;
        end
        S_ADR: if (cyc_end) begin
          tmr <= '0;
          aix <= aix + 1'b1;
          if (aix == AIW'(AC - 1))
            st <= (op == K_RD) ? S_BSY : (op == K_PG) ? S_WR : S_CFM;
        end
        S_WR: if (!act) begin
          if (wr_valid) begin
            dbuf <= wr_data; lastb <= wr_last; act <= 1'b1; tmr <= '0;
          end
        end else if (cyc_end) begin
          tmr <= '0; act <= 1'b0; col <= col + 1'b1;
          if (lastb || page_end) st <= S_CFM;
        end
        S_CFM: if (cyc_end) begin
          tmr <= '0; st <= S_BSY;
        end
        S_BSY: if (tmr >= WB && rb_n) begin
          tmr <= '0;
          if (op == K_RD)      st <= S_RD;
          else if (op == K_RS) begin st <= S_IDLE; done_q <= 1'b1; end
          else                 st <= S_SCMD;
        end else if (tmr == TO) begin
          err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
        end
        S_RD: if (cyc_end) begin
          tmr <= '0; st <= S_OUT;
        end
        S_OUT: if (rd_ready) begin
          if (page_end) begin st <= S_IDLE; done_q <= 1'b1; end
          else begin col <= col + 1'b1; st <= S_RD; end
        end
        S_SCMD: if (cyc_end) begin
          tmr <= '0; st <= S_SRD;
        end
        S_SRD: if (cyc_end) begin
          st <= S_IDLE; done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] re_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_run <= '0;
    else        re_run <= re_n ? 8'd0 : re_run + 8'd1;
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R3
  AST_RE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> (!io_oe && !cle && !ale)); // R3
  AST_STROBE_CE:  assert property (@(posedge clk) disable iff (!rst_n) (!we_n || !re_n) |-> !ce_n); // R2
  AST_WP_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
                    (!we_n && cle && (io_out == OPC_PCFM || io_out == OPC_ECFM)) |-> wp_n); // R6
  AST_RE_WIDTH:   assert property (@(posedge clk) disable iff (!rst_n) $rose(re_n) |-> (re_run == 8'(RE_LO))); // R8
  AST_RD_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R7
  AST_WE_BUS:     assert property (@(posedge clk) disable iff (!rst_n) (!we_n && $past(!we_n)) |-> $stable(io_out)); // R3
endmodule

// File: tb/nand_host_ctrl_tb.sv
`timescale 1ns/1ps
module nand_host_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [9:0] req_block = 0;
  logic [3:0] req_page = 0;
  logic [9:0] req_col = 0;
  logic done, err;
  logic [7:0] status;
  logic wr_valid = 0, wr_ready, wr_last = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid, rd_ready = 0;
  logic [7:0] rd_data;
  logic ce_n, cle, ale, we_n, re_n, wp_n, io_oe, rb_n;
  logic [7:0] io_out, io_in;

  nand_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_block(req_block), .req_page(req_page), .req_col(req_col), .done(done), .err(err),
    .status(status), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural flash device
  localparam int BT = 300;
  int bsy = 0;
  bit hang = 0, failnext = 0, smode = 0;
  logic pwe = 1, pre = 1;
  logic [7:0] cur = 0, sval = 8'hC0, dout = 0;
  logic [7:0] ab [4];
  int an = 0, pcnt = 0, rrow = 0, rcol = 0;
  logic [7:0] pbuf [528];
  logic [7:0] mem [int];
  logic [9:0] wlog [1024];
  int wn = 0;
  int v_lat = 0, v_wp = 0, v_rbusy = 0, v_rlo = 0, v_rhi = 0, relo = 0, rehi = 1000;

  assign rb_n  = (bsy == 0);
  assign io_in = dout;

  always @(posedge clk) begin
    if (!hang && bsy > 0) bsy <= bsy - 1;
    if (cle && ale) v_lat++;
    if (!re_n && (io_oe || cle || ale)) v_lat++;
    if (!pwe && we_n) begin
      if (wn < 1024) wlog[wn] = {cle ? 2'd0 : ale ? 2'd1 : 2'd2, io_out};
      wn++;
      if (cle) begin
        cur = io_out;
        case (io_out)
          8'h80: begin pcnt = 0; an = 0; smode = 0; end
          8'h00: begin an = 0; smode = 0; end
          8'h60: an = 0;
          8'h10: begin
            if (!wp_n) v_wp++;
            for (int i = 0; i < pcnt; i++)
              mem[{ab[3][5:0], ab[2]} * 1024 + {ab[1][1:0], ab[0]} + i] = pbuf[i];
            sval = failnext ? 8'hC1 : 8'hC0;
            failnext = 0;
            bsy <= BT;
          end
          8'hD0: begin
            if (!wp_n) v_wp++;
            for (int p = 0; p < 16; p++)
              for (int c = 0; c < 528; c++)
                if (mem.exists(({ab[1][5:0], ab[0]} & 14'h3FF0 | p) * 1024 + c))
                  mem.delete(({ab[1][5:0], ab[0]} & 14'h3FF0 | p) * 1024 + c);
            sval = 8'hC0;
            bsy <= BT;
          end
          8'h70: smode = 1;
          8'hFF: begin smode = 0; bsy <= BT / 3; end
          default: ;
        endcase
      end else if (ale) begin
        if (an < 4) ab[an] = io_out;
        an++;
        if (cur == 8'h00 && an == 4) begin
          rrow = {ab[3][5:0], ab[2]};
          rcol = {ab[1][1:0], ab[0]};
          bsy <= BT;
        end
      end else begin
        if (pcnt < 528) pbuf[pcnt] = io_out;
        pcnt++;
      end
    end
    if (!re_n) relo++;
    if (pre && !re_n) begin
      if (rehi < 5) v_rhi++;
      if (!rb_n) v_rbusy++;
      if (smode) dout <= sval;
      else begin
        dout <= mem.exists(rrow * 1024 + rcol) ? mem[rrow * 1024 + rcol] : 8'hFF;
        rcol++;
      end
    end
    if (!pre && re_n) begin
      if (relo != 5) v_rlo++;
      relo = 0;
      rehi = 0;
    end
    if (re_n) rehi++;
    pwe = we_n;
    pre = re_n;
  end

  // bench-side shadow of page contents
  logic [7:0] shadow [int];
  logic [7:0] wdat [600];
  logic [7:0] rdat [528];
  int rcnt = 0, acc = 0, cyc = 0;

  function automatic logic [7:0] exp_addr(input int k, input int blk, input int pg, input int col);
    int row = blk * 16 + pg;
    case (k)
      0: return 8'(col & 255);
      1: return 8'(col >> 8);
      2: return 8'(row & 255);
      default: return 8'(row >> 8);
    endcase
  endfunction

  task automatic run_op(input int opc, input int blk, input int pg, input int col, input int n);
    bit seen = 0, hs_w;
    int idx = 0;
    wn = 0; rcnt = 0; cyc = 0;
    @(negedge clk);
    req_op = 3'(opc); req_block = 10'(blk); req_page = 4'(pg); req_col = 10'(col); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!seen && cyc < 20000) begin
      wr_valid = (idx < n);
      wr_data  = wdat[idx < 600 ? idx : 0];
      wr_last  = (idx == n - 1);
      rd_ready = ($urandom_range(0, 3) != 0);
      #1;
      hs_w = wr_valid && wr_ready;
      if (rd_valid && rd_ready && rcnt < 528) begin rdat[rcnt] = rd_data; rcnt++; end
      if (done) seen = 1;
      @(negedge clk);
      if (hs_w) idx++;
      cyc++;
    end
    wr_valid = 0; wr_last = 0; rd_ready = 0;
    acc = idx;
    if (!seen) chk(0, "WATCHDOG", cyc, 0);
  endtask

  task automatic do_program(input int blk, input int pg, input int col, input int n, input bit fl);
    int room = 528 - col;
    int k = (n < room) ? n : room;
    for (int i = 0; i < n && i < 600; i++) wdat[i] = 8'($urandom);
    failnext = fl;
    run_op(1, blk, pg, col, n);
    chk(acc == k, "R5 accepted byte count", acc, k);
    chk(wn == 7 + k, "R5 write cycle count", wn, 7 + k);
    chk(wlog[0] == {2'd0, 8'h80}, "R2 program opcode", wlog[0], {2'd0, 8'h80});
    for (int a = 0; a < 4; a++)
      chk(wlog[1 + a] == {2'd1, exp_addr(a, blk, pg, col)}, "R4 program address", wlog[1 + a], {2'd1, exp_addr(a, blk, pg, col)});
    for (int i = 0; i < k; i++) begin
      if (wlog[5 + i] != {2'd2, wdat[i]}) begin chk(0, "R5 data byte", wlog[5 + i], {2'd2, wdat[i]}); break; end
      shadow[(blk * 16 + pg) * 1024 + col + i] = wdat[i];
    end
    chk(wlog[5 + k] == {2'd0, 8'h10}, "R5 confirm after data", wlog[5 + k], {2'd0, 8'h10});
    chk(wlog[6 + k] == {2'd0, 8'h70}, "R9 status command", wlog[6 + k], {2'd0, 8'h70});
    chk(status == (fl ? 8'hC1 : 8'hC0), "R9 status byte", status, fl ? 8'hC1 : 8'hC0);
    chk(err == 0, "R10 no error", err, 0);
    chk(v_wp == 0, "R6 wp_n at confirm", v_wp, 0);
    chk(wp_n == 0 && req_ready == 1, "R6 wp_n low when idle", wp_n, 0);
  endtask

  task automatic do_read(input int blk, input int pg, input int col);
    int mism = 0;
    run_op(0, blk, pg, col, 0);
    chk(wn == 5, "R4 read write cycles", wn, 5);
    chk(wlog[0] == {2'd0, 8'h00}, "R2 read opcode", wlog[0], 0);
    for (int a = 0; a < 4; a++)
      chk(wlog[1 + a] == {2'd1, exp_addr(a, blk, pg, col)}, "R4 read address", wlog[1 + a], {2'd1, exp_addr(a, blk, pg, col)});
    chk(rcnt == 528 - col, "R7 read byte count", rcnt, 528 - col);
    for (int i = 0; i < rcnt; i++) begin
      int key = (blk * 16 + pg) * 1024 + col + i;
      logic [7:0] e = shadow.exists(key) ? shadow[key] : 8'hFF;
      if (rdat[i] != e) begin
        if (mism == 0) chk(0, "R7 read data", rdat[i], e);
        mism++;
      end
    end
    if (mism == 0) chk(1, "R7 read data", 0, 0);
    chk(v_rbusy == 0, "R7 no RE while busy", v_rbusy, 0);
    chk(v_rlo == 0 && v_rhi == 0, "R8 RE low/high widths", v_rlo + v_rhi, 0);
    chk(v_lat == 0, "R3 latch enables", v_lat, 0);
  endtask

  int t0;
  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(req_ready == 1 && ce_n == 1 && we_n == 1 && re_n == 1 && wp_n == 0 && io_oe == 0 && done == 0,
        "R1 reset state", {req_ready, ce_n, we_n, re_n, wp_n, io_oe, done}, 7'b1111000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && err == 0, "R1 idle after reset", {req_ready, err}, 2'b10);

    do_program(3, 2, 0, 528, 0);
    do_read(3, 2, 0);
    do_program(1023, 15, 500, 40, 0);   // page-end cut-off, R5
    do_read(1023, 15, 520);
    do_program(7, 0, 100, 10, 1);       // device reports failure, R9
    do_read(7, 0, 100);
    for (int it = 0; it < 4; it++) begin
      int b = $urandom_range(0, 1023), p = $urandom_range(0, 15), c = $urandom_range(0, 527);
      int n = $urandom_range(1, 560 - c);
      do_program(b, p, c, n, 0);
      do_read(b, p, c);
    end

    // erase of block 3, R4 row-only address
    run_op(2, 3, 9, 0, 0);
    chk(wn == 5, "R4 erase write cycles", wn, 5);
    chk(wlog[0] == {2'd0, 8'h60}, "R2 erase opcode", wlog[0], {2'd0, 8'h60});
    chk(wlog[1] == {2'd1, 8'h30} && wlog[2] == {2'd1, 8'h00}, "R4 erase row bytes", {wlog[1], wlog[2]}, {2'd1, 8'h30, 2'd1, 8'h00});
    chk(wlog[3] == {2'd0, 8'hD0}, "R2 erase confirm", wlog[3], {2'd0, 8'hD0});
    chk(wlog[4] == {2'd0, 8'h70} && status == 8'hC0, "R9 erase status", status, 8'hC0);
    chk(v_wp == 0, "R6 wp_n at erase confirm", v_wp, 0);
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 528; c++)
        if (shadow.exists((48 + p) * 1024 + c)) shadow.delete((48 + p) * 1024 + c);
    do_read(3, 2, 0);

    // status and reset operations, R11
    sval = 8'hE0;
    run_op(3, 0, 0, 0, 0);
    chk(wn == 1 && wlog[0] == {2'd0, 8'h70}, "R11 status op writes", wn, 1);
    chk(status == 8'hE0, "R11 status op byte", status, 8'hE0);
    run_op(4, 0, 0, 0, 0);
    chk(wn == 1 && wlog[0] == {2'd0, 8'hFF}, "R11 reset op writes", wn, 1);
    chk(cyc >= BT / 3 - 2, "R11 reset waits ready", cyc, BT / 3);

    // busy timeout, R10
    hang = 1;
    run_op(2, 5, 0, 0, 0);
    chk(err == 1, "R10 timeout flag", err, 1);
    chk(cyc >= 12000, "R10 timeout length", cyc, 12000);
    chk(req_ready == 1 && wp_n == 0, "R10 back to idle", {req_ready, wp_n}, 2'b10);
    hang = 0;
    repeat (BT + 5) @(negedge clk);
    sval = 8'hC0;
    run_op(3, 0, 0, 0, 0);
    chk(err == 0, "R10 err cleared by next request", err, 1'b0);
    chk(v_lat == 0, "R3 latch enables overall", v_lat, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "WATCHDOG global", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule